// File: doc/BRIEF.md
# Privilege-Qualified Branch Trace Recorder

The recorder takes branch events over a valid/ready input, each event carrying a source address, a destination address and the privilege level in force at the time of the branch. Five control bits decide, per event, whether a trace message is emitted and whether the event is written to a record buffer in memory. Storage can be restricted to kernel-level branches (privilege 0) or to user-level branches (privilege above 0).

The buffer is described by four pointers: a base, a current index, an absolute maximum and an interrupt threshold. Each stored record takes three 64-bit words, written over a simple memory write port. In circular mode the index wraps back to the base when the next record would not fit. In interrupt mode a level interrupt is raised when the index reaches the threshold. Records arriving after the buffer fills are dropped, and the interrupt stays high until software rewrites the index. A base-to-maximum span too small for one record is reported as a configuration error, and no record is stored while it lasts.

Top module: `branch_trace_rec`

## Requirements
- R1: With control bit 0 (trace enable) clear, an accepted event produces no message pulse on `msg_valid_o` and no memory write, whatever the other control bits hold.
- R2: With trace enable set and control bit 1 (store enable) clear, each accepted event gives a one-cycle `msg_valid_o` pulse in the cycle after acceptance, and nothing is written.
- R3: With trace and store enabled and control bit 2 (kernel-off) set, events with privilege 0 are not stored and events with privilege above 0 are stored.
- R4: With trace and store enabled and control bit 3 (user-off) set, events with privilege above 0 are not stored and events with privilege 0 are stored.
- R5: With kernel-off and user-off both set, no event is stored and messages are still produced, whatever control bit 4 holds.
- R6: With control bit 4 (interrupt mode) clear, after a store the index advances by 24 and returns to the base when a further record would pass the absolute maximum; a record found at an index that no longer fits is written at the base.
- R7: With interrupt mode set, `irq_o` is high while the index is equal to or above the threshold pointer, and low while it is below.
- R8: With interrupt mode clear, `irq_o` stays low wherever the threshold lies.
- R9: In interrupt mode, an event that would be stored but does not fit below the absolute maximum is dropped without a write. The index is set to the absolute maximum, `irq_o` stays high, and the control register keeps its value until software writes the index.
- R10: When base + 24 exceeds the absolute maximum, `cfg_err_o` is high and no event is stored; messages are still produced.
- R11: A stored record is three consecutive write cycles starting in the cycle after acceptance: the source address at the index, the destination address at index+8, and a flags word holding the privilege in bits [1:0] (all other bits zero) at index+16. `ev_ready_o` is low during these three cycles.
- R12: The register port maps address 0 to the control bits [4:0], 1 to the base, 2 to the index, 3 to the absolute maximum and 4 to the threshold. Writes take effect at the clock edge, reads are combinational, and a software write to the index takes priority over a hardware update. After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Branch event valid |
| ev_ready_o | output | 1 | Recorder can accept an event |
| ev_from_i | input | ADDR_W | Branch source address |
| ev_to_i | input | ADDR_W | Branch destination address |
| ev_priv_i | input | 2 | Privilege level of the branch |
| msg_valid_o | output | 1 | One-cycle pulse per emitted trace message |
| mem_we_o | output | 1 | Record word write strobe |
| mem_addr_o | output | ADDR_W | Record word byte address |
| mem_wdata_o | output | 64 | Record word data |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data |
| irq_o | output | 1 | Buffer threshold interrupt, level |
| cfg_err_o | output | 1 | Buffer span smaller than one record |

## Verification
A wrong privilege filter decision shows within a cycle of acceptance, as an extra or missing write burst that the scoreboard reports when it pops or when it finds its queue non-empty at idle. A wrong index update shows on the next stored record as a wrong write address, and at once on a readback of the index. A wrong threshold comparison or a failure to saturate shows on `irq_o` in the cycle after the event that moved the index.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int REC_WORDS  = 3;
  localparam int WORD_BYTES = 8;
  localparam int REC_BYTES  = REC_WORDS * WORD_BYTES;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_IDX  = 3'd2;
  localparam logic [2:0] RA_MAX  = 3'd3;
  localparam logic [2:0] RA_THR  = 3'd4;

  typedef struct packed {
    logic irq_mode;
    logic usr_off;
    logic os_off;
    logic store_en;
    logic trace_en;
  } ctrl_t;
endpackage

// File: rtl/brt_filter.sv
module brt_filter
  import brt_pkg::*;
(
  input  ctrl_t      ctrl_i,
  input  logic [1:0] priv_i,
  input  logic       cfg_err_i,
  input  logic       room_i,
  output logic       msg_o,
  output logic       want_o,
  output logic       store_o
);
  logic blocked;

  // level 0 is kernel, any other level is user
  assign blocked = (priv_i == 2'd0) ? ctrl_i.os_off : ctrl_i.usr_off;
  assign msg_o   = ctrl_i.trace_en;
  assign want_o  = ctrl_i.trace_en && ctrl_i.store_en && !blocked && !cfg_err_i;
  assign store_o = want_o && room_i;
endmodule

// File: rtl/brt_index.sv
module brt_index
  import brt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] max_i,
  input  logic              sw_we_i,
  input  logic [ADDR_W-1:0] sw_idx_i,
  input  logic              commit_i,
  input  logic              drop_i,
  output logic [ADDR_W-1:0] idx_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic              room_o,
  output logic              cfg_err_o
);
  localparam logic [ADDR_W:0] REC = (ADDR_W+1)'(REC_BYTES);

  logic [ADDR_W-1:0] idx_q, nxt_idx;
  logic [ADDR_W:0]   idx_x, base_x, max_x, st_x, nxt_x;
  logic              fits;

  assign idx_x  = {1'b0, idx_q};
  assign base_x = {1'b0, base_i};
  assign max_x  = {1'b0, max_i};

  assign cfg_err_o = (base_x + REC) > max_x;
  assign fits      = (idx_x + REC) <= max_x;
  assign room_o    = !irq_mode_i || fits;
  // circular mode restarts at base when the index no longer fits
  assign st_x      = (irq_mode_i || fits) ? idx_x : base_x;
  assign nxt_x     = st_x + REC;
  assign nxt_idx   = (!irq_mode_i && (nxt_x + REC) > max_x) ? base_i : nxt_x[ADDR_W-1:0];
  assign st_addr_o = st_x[ADDR_W-1:0];
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (sw_we_i)  idx_q <= sw_idx_i;
    else if (commit_i) idx_q <= nxt_idx;
    else if (drop_i)   idx_q <= max_i;
  end

  // R9
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i && !sw_we_i |=> idx_q == $past(max_i));
  // R6
  wrap_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !sw_we_i && !irq_mode_i && !cfg_err_o |=>
      ({1'b0, idx_q} + REC) <= {1'b0, $past(max_i)});
endmodule

// File: rtl/brt_writer.sv
module brt_writer
  import brt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] from_i,
  input  logic [ADDR_W-1:0] to_i,
  input  logic [1:0]        priv_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_wdata_o
);
  localparam int CNT_W = $clog2(REC_WORDS);
  localparam int SH    = $clog2(WORD_BYTES);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q, from_q, to_q;
  logic [1:0]        priv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      from_q <= '0;
      to_q   <= '0;
      priv_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        addr_q <= addr_i;
        from_q <= from_i;
        to_q   <= to_i;
        priv_q <= priv_i;
      end
    end else if (cnt_q == CNT_W'(REC_WORDS - 1)) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign mem_we_o   = busy_q;
  assign mem_addr_o = addr_q + (ADDR_W'(cnt_q) << SH);

  always_comb begin
    case (cnt_q)
      CNT_W'(0): mem_wdata_o = 64'(from_q);
      CNT_W'(1): mem_wdata_o = 64'(to_q);
      default:   mem_wdata_o = {62'd0, priv_q};
    endcase
  end

  // R11
  word_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && $past(mem_we_o) && $past(cnt_q) != CNT_W'(REC_WORDS - 1) |->
      mem_addr_o == $past(mem_addr_o) + ADDR_W'(WORD_BYTES));
endmodule

// File: rtl/branch_trace_rec.sv
module branch_trace_rec
  import brt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  output logic              ev_ready_o,
  input  logic [ADDR_W-1:0] ev_from_i,
  input  logic [ADDR_W-1:0] ev_to_i,
  input  logic [1:0]        ev_priv_i,
  output logic              msg_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              cfg_err_o
);
  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] base_q, max_q, thr_q, idx, st_addr;
  logic              busy, accept, msg, want, store, room;
  logic              msg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      base_q <= '0;
      max_q  <= '0;
      thr_q  <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        RA_CTRL: ctrl_q <= ctrl_t'(reg_wdata_i[$bits(ctrl_t)-1:0]);
        RA_BASE: base_q <= reg_wdata_i[ADDR_W-1:0];
        RA_MAX:  max_q  <= reg_wdata_i[ADDR_W-1:0];
        RA_THR:  thr_q  <= reg_wdata_i[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_i)
      RA_CTRL: reg_rdata_o = 64'(ctrl_q);
      RA_BASE: reg_rdata_o = 64'(base_q);
      RA_IDX:  reg_rdata_o = 64'(idx);
      RA_MAX:  reg_rdata_o = 64'(max_q);
      RA_THR:  reg_rdata_o = 64'(thr_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign ev_ready_o = !busy;
  assign accept     = ev_valid_i && ev_ready_o;

  brt_filter u_filter (
    .ctrl_i    (ctrl_q),
    .priv_i    (ev_priv_i),
    .cfg_err_i (cfg_err_o),
    .room_i    (room),
    .msg_o     (msg),
    .want_o    (want),
    .store_o   (store)
  );

  brt_index #(.ADDR_W(ADDR_W)) u_index (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_mode_i (ctrl_q.irq_mode),
    .base_i     (base_q),
    .max_i      (max_q),
    .sw_we_i    (reg_we_i && reg_addr_i == RA_IDX),
    .sw_idx_i   (reg_wdata_i[ADDR_W-1:0]),
    .commit_i   (accept && store),
    .drop_i     (accept && want && !room),
    .idx_o      (idx),
    .st_addr_o  (st_addr),
    .room_o     (room),
    .cfg_err_o  (cfg_err_o)
  );

  brt_writer #(.ADDR_W(ADDR_W)) u_writer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept && store),
    .addr_i      (st_addr),
    .from_i      (ev_from_i),
    .to_i        (ev_to_i),
    .priv_i      (ev_priv_i),
    .busy_o      (busy),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) msg_q <= 1'b0;
    else         msg_q <= accept && msg;
  end

  assign msg_valid_o = msg_q;
  assign irq_o       = ctrl_q.irq_mode && (idx >= thr_q);

  // R1
  trace_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !ctrl_q.trace_en |=> !msg_valid_o && !mem_we_o);
  // R5
  both_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && ctrl_q.os_off && ctrl_q.usr_off |=> !mem_we_o);
  // R10
  cfg_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && cfg_err_o |=> !mem_we_o);
  // R11
  ready_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !ev_ready_o);
  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !reg_we_i |=> irq_o);
  // R8
  no_circ_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.irq_mode |-> !irq_o);
endmodule

// File: tb/branch_trace_rec_tb.sv
`timescale 1ns/1ps
module branch_trace_rec_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0;
  logic          ev_ready;
  logic [AW-1:0] ev_from = '0, ev_to = '0;
  logic [1:0]    ev_priv = '0;
  logic          msg_valid, mem_we, irq, cfg_err;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, reg_rdata;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [63:0]   reg_wdata = '0;

  always #2.5 clk = ~clk;

  branch_trace_rec #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_valid_i(ev_valid), .ev_ready_o(ev_ready),
    .ev_from_i(ev_from), .ev_to_i(ev_to), .ev_priv_i(ev_priv),
    .msg_valid_o(msg_valid),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq), .cfg_err_o(cfg_err)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  logic [4:0]    m_ctrl = '0;
  logic [AW-1:0] m_base = '0, m_max = '0, m_idx = '0, m_thr = '0;

  logic [AW-1:0] q_addr[$];
  logic [63:0]   q_data[$];
  string         q_tag[$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: pops expected record words as the design writes them
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (q_addr.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL %s: actual write %h@%h expected none", "R1-5,R9,R10 unexpected store",
                 mem_wdata, mem_addr);
      end else begin
        chk({q_tag[0], " addr"}, 64'(mem_addr), 64'(q_addr[0]));
        chk({q_tag[0], " data"}, mem_wdata, q_data[0]);
        void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      3'd0: m_ctrl = d[4:0];
      3'd1: m_base = d[AW-1:0];
      3'd2: m_idx  = d[AW-1:0];
      3'd3: m_max  = d[AW-1:0];
      3'd4: m_thr  = d[AW-1:0];
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  // driver: computes expectation, pushes it, then drives the event
  task automatic send(string tag, logic [AW-1:0] f, logic [AW-1:0] t, logic [1:0] p);
    logic cerr, want, fits;
    logic [AW-1:0] a, n;
    cerr = ({1'b0, m_base} + 33'd24) > {1'b0, m_max};
    fits = ({1'b0, m_idx} + 33'd24) <= {1'b0, m_max};
    want = m_ctrl[0] && m_ctrl[1] && !cerr && !((p == 2'd0) ? m_ctrl[2] : m_ctrl[3]);
    if (want) begin
      if (m_ctrl[4] && !fits) begin
        m_idx = m_max;
      end else begin
        a = fits ? m_idx : m_base;
        q_addr.push_back(a);      q_data.push_back(64'(f));       q_tag.push_back(tag);
        q_addr.push_back(a + 8);  q_data.push_back(64'(t));       q_tag.push_back(tag);
        q_addr.push_back(a + 16); q_data.push_back({62'd0, p});   q_tag.push_back(tag);
        n = a + 24;
        m_idx = (!m_ctrl[4] && ({1'b0, n} + 33'd24) > {1'b0, m_max}) ? m_base : n;
      end
    end
    @(negedge clk);
    ev_valid = 1'b1; ev_from = f; ev_to = t; ev_priv = p;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    chk({tag, " msg pulse (R1/R2)"}, 64'(msg_valid), 64'(m_ctrl[0]));
  endtask

  task automatic settle(string tag);
    logic [63:0] d;
    repeat (6) @(negedge clk);
    chk({tag, " pending writes"}, 64'(q_addr.size()), 64'd0);
    rd(3'd2, d);
    chk({tag, " index R6/R12"}, d, 64'(m_idx));
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 ready at reset", 64'(ev_ready), 64'd1);
    chk("R12 irq at reset", 64'(irq), 64'd0);
    chk("R12 mem_we at reset", 64'(mem_we), 64'd0);
    rst_n = 1'b1;
    rd(3'd2, d); chk("R12 index reset", d, 64'd0);
    rd(3'd0, d); chk("R12 ctrl reset", d, 64'd0);
    chk("R10 cfg_err with zero span", 64'(cfg_err), 64'd1);

    wr(3'd1, 64'h1000); wr(3'd3, 64'h1060); wr(3'd2, 64'h1000); wr(3'd4, 64'h2000);
    chk("R10 cfg_err cleared", 64'(cfg_err), 64'd0);

    // R1: trace off
    wr(3'd0, 64'h1E);
    send("R1", 32'hA000, 32'hB000, 2'd0);
    settle("R1");
    // R2: trace on, store off
    wr(3'd0, 64'h01);
    send("R2", 32'hA004, 32'hB004, 2'd3);
    settle("R2");

    // R6/R11: circular, store all, wrap after 4 records
    wr(3'd0, 64'h03);
    for (int i = 0; i < 6; i++)
      send("R6/R11", 32'hC000 + 32'(i * 4), 32'hD000 + 32'(i * 4), 2'(i));
    settle("R6");
    chk("R8 irq circular", 64'(irq), 64'd0);

    // R3: kernel-off
    wr(3'd0, 64'h07);
    send("R3 priv0", 32'hE000, 32'hE100, 2'd0);
    send("R3 priv2", 32'hE004, 32'hE104, 2'd2);
    settle("R3");
    // R4: user-off
    wr(3'd0, 64'h0B);
    send("R4 priv1", 32'hE008, 32'hE108, 2'd1);
    send("R4 priv0", 32'hE00C, 32'hE10C, 2'd0);
    settle("R4");
    // R5: both off, interrupt bit set and clear
    wr(3'd0, 64'h1F);
    send("R5 priv0", 32'hE010, 32'hE110, 2'd0);
    wr(3'd0, 64'h0F);
    send("R5 priv3", 32'hE014, 32'hE114, 2'd3);
    settle("R5");

    // R8: circular with threshold inside the buffer
    wr(3'd0, 64'h03); wr(3'd2, 64'h1000); wr(3'd4, 64'h1018);
    send("R8", 32'hF000, 32'hF100, 2'd1);
    send("R8", 32'hF004, 32'hF104, 2'd1);
    settle("R8");
    chk("R8 irq low in circular", 64'(irq), 64'd0);

    // R7/R9: interrupt mode
    wr(3'd2, 64'h1000); wr(3'd4, 64'h1030); wr(3'd0, 64'h13);
    send("R7 s1", 32'h9000, 32'h9100, 2'd0);
    chk("R7 irq below thr", 64'(irq), 64'd0);
    send("R7 s2", 32'h9004, 32'h9104, 2'd1);
    repeat (4) @(negedge clk);
    chk("R7 irq at thr", 64'(irq), 64'd1);
    send("R7 s3", 32'h9008, 32'h9108, 2'd2);
    send("R7 s4", 32'h900C, 32'h910C, 2'd3);
    send("R9 drop", 32'h9010, 32'h9110, 2'd0);
    send("R9 drop2", 32'h9014, 32'h9114, 2'd1);
    settle("R9");
    chk("R9 irq held", 64'(irq), 64'd1);
    rd(3'd0, d); chk("R9 ctrl kept", d, 64'h13);
    wr(3'd2, 64'h1000);
    chk("R9 irq cleared by index write", 64'(irq), 64'd0);

    // R10: span too small
    wr(3'd3, 64'h1010);
    chk("R10 cfg_err", 64'(cfg_err), 64'd1);
    send("R10", 32'h7000, 32'h7100, 2'd0);
    settle("R10");

    summary();
  end
endmodule